// File: doc/BRIEF.md
# Register List Load/Store Sequencer

This block moves a group of registers between the register file and memory in response to one command. The command carries a base address, a five-bit list field, a direction (load into registers or store to memory) and an access size (word or doubleword). The sequencer walks a fixed list of callee-saved registers, 16 to 23 and then 30. If requested, it finishes with the return-address register, 31.

Each transfer is one memory beat. The request is held until memory answers with ready. During the beat the sequencer drives the register-file read address for a store, or the register-file write port for a load. It raises done for a single cycle when the list is exhausted. Faults, pipeline hookup and the register file itself are outside the block.

Top module: `lsm_seq`

## Requirements
- R1: After reset the block is idle. busy, done, mem_req and rf_we are all low.
- R2: list[3:0] is the number of table registers to move. The registers are visited in the fixed order 16, 17, 18, 19, 20, 21, 22, 23, 30, starting at the base address.
- R3: A count of 0, or a count from 10 to 15, moves no table registers.
- R4: When list[4] is 1, register 31 is moved after all table registers, at the next sequential address.
- R5: The address rises by 4 per beat for word accesses (is_dword=0) and by 8 per beat for doubleword accesses (is_dword=1).
- R6: A load writes rf_wdata to rf_addr with rf_we high in the beat where mem_ready is high. A word load sign-extends mem_rdata[31:0] to 64 bits. A doubleword load takes all 64 bits.
- R7: A store (is_store=1) drives mem_we high. mem_wdata is the register value read through rf_rdata: the full 64 bits for a doubleword, or the low 32 bits with the upper half zero for a word.
- R8: mem_req stays high with a stable address, register and direction until mem_ready is seen. One transfer completes per ready cycle.
- R9: done is high for exactly one cycle, in the cycle after the last beat is accepted. If nothing is to be moved, done is high in the cycle after start.
- R10: A start seen while busy is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, taken only when idle |
| base_addr | input | AW | First byte address |
| reg_list | input | 5 | [3:0] table count, [4] add register 31 |
| is_store | input | 1 | 1 = store to memory, 0 = load to registers |
| is_dword | input | 1 | 1 = doubleword, 0 = word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_addr | output | 5 | Register-file index for the current beat |
| rf_rdata | input | 2*WORD_W | Register value at rf_addr |
| rf_we | output | 1 | Register-file write enable (loads) |
| rf_wdata | output | 2*WORD_W | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_dword | output | 1 | Access size of the request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 2*WORD_W | Store data |
| mem_rdata | input | 2*WORD_W | Load data |
| mem_ready | input | 1 | Memory accepts the beat |

## Verification
Several corner cases are driven on purpose, each with the failure it would expose.
- A count of 9 must reach register 30, not 24; a design that computes the register number arithmetically would get this wrong.
- Counts of 10 to 15, with and without the register-31 bit, must produce either no beats at all or a single beat for register 31. A design that treats the count as a plain loop bound would run past the table.
- Word loads are fed memory data with set upper bits and negative low words, so a missing or wrong sign extension shows up in rf_wdata.
- Stalls from a randomly withheld ready, and a second start issued mid-sequence, catch designs that advance without a handshake or restart on a new command.

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int AW     = 32,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       base_addr,
  input  logic [4:0]          reg_list,
  input  logic                is_store,
  input  logic                is_dword,
  output logic                busy,
  output logic                done,
  output logic [4:0]          rf_addr,
  input  logic [2*WORD_W-1:0] rf_rdata,
  output logic                rf_we,
  output logic [2*WORD_W-1:0] rf_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_dword,
  output logic [AW-1:0]       mem_addr,
  output logic [2*WORD_W-1:0] mem_wdata,
  input  logic [2*WORD_W-1:0] mem_rdata,
  input  logic                mem_ready
);
  localparam int WB      = WORD_W / 8;
  localparam int TBL_LEN = 9;

  logic          busy_q, done_q, st_q, dw_q, r31_q;
  logic [3:0]    cnt_q, idx_q;
  logic [AW-1:0] addr_q;

  wire       cnt_ok   = (reg_list[3:0] != 4'd0) && (reg_list[3:0] <= 4'(TBL_LEN));
  wire [3:0] cnt_in   = cnt_ok ? reg_list[3:0] : 4'd0;
  wire [3:0] total_in = cnt_in + {3'b000, reg_list[4]};
  wire [3:0] total_q  = cnt_q + {3'b000, r31_q};
  wire       last     = (idx_q == total_q - 4'd1);

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_req   = busy_q;
  assign mem_we    = st_q;
  assign mem_dword = dw_q;
  assign mem_addr  = addr_q;
  assign rf_we     = busy_q & mem_ready & ~st_q;

  assign rf_addr = (idx_q < cnt_q) ? ((idx_q == 4'd8) ? 5'd30 : 5'd16 + {1'b0, idx_q})
                                   : 5'd31;

  assign mem_wdata = dw_q ? rf_rdata : {{WORD_W{1'b0}}, rf_rdata[WORD_W-1:0]};
  assign rf_wdata  = dw_q ? mem_rdata
                          : {{WORD_W{mem_rdata[WORD_W-1]}}, mem_rdata[WORD_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      st_q   <= 1'b0;
      dw_q   <= 1'b0;
      r31_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          addr_q <= base_addr;
          cnt_q  <= cnt_in;
          r31_q  <= reg_list[4];
          st_q   <= is_store;
          dw_q   <= is_dword;
          idx_q  <= '0;
          if (total_in == 4'd0) done_q <= 1'b1;
          else                  busy_q <= 1'b1;
        end
      end else if (mem_ready) begin
        addr_q <= addr_q + (dw_q ? AW'(2*WB) : AW'(WB));
        idx_q  <= idx_q + 4'd1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic          mem_dword,
  input logic [AW-1:0] mem_addr,
  input logic [4:0]    rf_addr,
  input logic          rf_we
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !mem_req && !done); // R1
  AST_RF_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((rf_addr >= 5'd16 && rf_addr <= 5'd23) || rf_addr == 5'd30 || rf_addr == 5'd31)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req && mem_ready)) |->
      mem_addr == $past(mem_addr) + (mem_dword ? AW'(8) : AW'(4))); // R5
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ready && !mem_we)); // R6
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_addr) && $stable(mem_we))); // R8
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_req); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ready) |=> $stable(mem_addr)); // R10
endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we), .mem_dword(mem_dword),
  .mem_addr(mem_addr), .rf_addr(rf_addr), .rf_we(rf_we)
);

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [4:0]  reg_list = '0;
  logic        is_store = 1'b0, is_dword = 1'b0;
  logic        busy, done, rf_we, mem_req, mem_we, mem_dword;
  logic [4:0]  rf_addr;
  logic [63:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;

  always #2 clk = ~clk;

  lsm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .reg_list(reg_list),
    .is_store(is_store), .is_dword(is_dword), .busy(busy), .done(done),
    .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [63:0] rf [32];
  logic [7:0]  mem [4096];
  int vec = 0, bad = 0;

  function automatic logic [63:0] rdmem(input logic [31:0] a, input logic dw);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = mem[(a + 32'(i)) % 4096];
    if (!dw) r[63:32] = 32'hC3A5_F00D;
    return r;
  endfunction

  assign rf_rdata  = rf[rf_addr];
  assign mem_rdata = rdmem(mem_addr, mem_dword);

  function automatic int tbl(input int i);
    return (i < 8) ? 16 + i : 30;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] base, input logic [4:0] lst, input bit st,
                        input bit dw, input bit poke);
    int regs[10];
    int n = 0, k = 0, cyc = 0;
    logic [31:0] a = base;
    logic [63:0] exp;
    int cnt = int'(lst[3:0]);
    if (cnt >= 1 && cnt <= 9) for (int i = 0; i < cnt; i++) begin regs[n] = tbl(i); n++; end
    if (lst[4]) begin regs[n] = 31; n++; end
    @(negedge clk);
    start = 1'b1; base_addr = base; reg_list = lst; is_store = st; is_dword = dw;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      #1;
      chk(done && !mem_req, "R3/R9 empty list done", {62'b0, done, mem_req}, 64'h2);
      @(negedge clk); #1;
      chk(!done && !busy, "R9 single pulse", {62'b0, done, busy}, 64'h0);
      return;
    end
    while (k < n && cyc < 200) begin
      mem_ready = ($urandom % 3) != 0;
      if (poke && k == 1) begin start = 1'b1; base_addr = base + 32'd256; reg_list = 5'h01; end
      #1;
      chk(mem_req && !done, "R8 request held", {62'b0, mem_req, done}, 64'h2);
      chk(mem_addr == a, poke ? "R10 address" : "R5 address", 64'(mem_addr), 64'(a));
      chk(int'(rf_addr) == regs[k], regs[k] == 31 ? "R4 register" : "R2 register",
          64'(rf_addr), 64'(regs[k]));
      chk(mem_we == st, "R7 direction", 64'(mem_we), 64'(st));
      if (mem_ready) begin
        if (st) begin
          exp = dw ? rf[regs[k]] : {32'b0, rf[regs[k]][31:0]};
          chk(mem_wdata == exp && !rf_we, "R7 store data", mem_wdata, exp);
          for (int i = 0; i < (dw ? 8 : 4); i++) mem[(a + 32'(i)) % 4096] = mem_wdata[i*8 +: 8];
        end else begin
          exp = rdmem(a, dw);
          if (!dw) exp = {{32{exp[31]}}, exp[31:0]};
          chk(rf_we && rf_wdata == exp, "R6 load data", rf_wdata, exp);
          if (rf_we) rf[rf_addr] = rf_wdata;
        end
        k++;
        a = a + (dw ? 32'd8 : 32'd4);
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    mem_ready = 1'b0;
    #1;
    chk(done && !mem_req && !busy, "R9 done after last beat", {61'b0, done, mem_req, busy}, 64'h4);
    @(negedge clk); #1;
    chk(!done && !mem_req, poke ? "R10 no restart" : "R9 single pulse", {62'b0, done, mem_req}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++; bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !mem_req && !rf_we, "R1 reset state", {60'b0, busy, done, mem_req, rf_we}, 64'h0);
    rst_n = 1'b1;
    #1;
    chk(!busy && !done && !mem_req, "R1 idle after reset", {61'b0, busy, done, mem_req}, 64'h0);
    run_op(32'd64, 5'h19, 1'b0, 1'b1, 1'b0);
    run_op(32'd128, 5'h09, 1'b1, 1'b0, 1'b0);
    mem[512] = 8'h01; mem[513] = 8'h00; mem[514] = 8'h00; mem[515] = 8'h80;
    run_op(32'd512, 5'h01, 1'b0, 1'b0, 1'b0);
    run_op(32'd600, 5'h00, 1'b0, 1'b0, 1'b0);
    run_op(32'd600, 5'h0F, 1'b1, 1'b1, 1'b0);
    run_op(32'd600, 5'h1A, 1'b0, 1'b1, 1'b0);
    run_op(32'd608, 5'h10, 1'b1, 1'b0, 1'b0);
    run_op(32'd640, 5'h05, 1'b0, 1'b0, 1'b1);
    for (int t = 0; t < 300; t++)
      run_op(32'($urandom % 256) * 32'd8, 5'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule